// File: doc/BRIEF.md
# Self-Checking (15,7) Cyclic Encoder

This block turns a 7-bit information word into a 15-bit systematic codeword of a cyclic (15,7) code whose minimum distance is 5. The information bits pass unchanged into the low seven positions. The eight upper positions carry parity. Each parity bit is the XOR of a fixed subset of the information bits, and the subsets come from the code's generator polynomial.

A separate syndrome checker recomputes the remainder of every candidate codeword before that word is released. A clean remainder releases the word at once. A nonzero remainder makes the controller run the encoding again, up to a fixed retry budget. When the budget is spent and the word is still bad, the block completes with a fail flag raised. So a faulty word is never reported as good.

A test-only fault input flips one chosen parity bit of the candidate word. This lets the retry path and the fail path be driven from the ports.

Top module: `cyc_selfcheck_encoder`

## Requirements
- R1: After reset, `codeword` is all zeros and both `done` and `fail` are low.
- R2: On every completion, `codeword[6:0]` equals the information word that was captured with the accepted `start`.
- R3: Codeword bit 7+m (m = 0..7) holds the coefficient of x^m in the remainder, modulo g(x) = x^8 + x^7 + x^6 + x^4 + 1, of the sum of x^(8+k) over every set information bit k. Codeword bit k (k = 0..6) stands for the term x^(8+k) in that division.
- R4: When no fault is injected, `done` rises two clock cycles after the edge that captures `start`. It stays high for exactly one cycle.
- R5: The syndrome checker rejects any candidate word whose remainder is nonzero. If the injected fault is present only on the first attempt, a second encoding releases the correct codeword with `fail` low, two cycles later than a clean run.
- R6: With `MAX_RETRY` = 2, a fault present on every attempt ends after three attempts, six cycles after capture. It ends with `done` and `fail` both high, and the released word carries the flipped parity bit. Parity bit m is flipped when `fault_en` is 1 and `fault_sel` = m, on the first `FAULT_ATTEMPTS` attempts only.
- R7: A `start` seen while an encoding is in progress is ignored. It changes neither the result nor the number of `done` pulses.
- R8: `codeword` and `fail` hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to encode `info`, taken when idle |
| info | input | K (7) | Information word |
| fault_en | input | 1 | Test-only: inject a parity fault for this request |
| fault_sel | input | SEL_W (3) | Test-only: index of the parity bit to flip |
| codeword | output | N (15) | Registered codeword; information in bits 6:0, parity in bits 14:7 |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Set with `done` when every allowed attempt failed the check |

## Verification
Both bench instances use N = 15, K = 7, the default generator and MAX_RETRY = 2. The instance named `dut` keeps FAULT_ATTEMPTS = 1, so an injected fault clears on the retry and the recovery latency can be measured. A second instance sets FAULT_ATTEMPTS = 3, so the fault lasts through the whole retry budget. Only that instance can reach the fail completion and release a word with the flipped parity bit.

// File: rtl/cyc_enc_pkg.sv
package cyc_enc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ENC  = 2'd1,
        ST_CHK  = 2'd2
    } enc_state_e;

    // Remainder of x^e modulo a generator of degree deg (deg <= 32).
    function automatic logic [31:0] xpow_mod(input int unsigned e,
                                             input int unsigned deg,
                                             input logic [32:0] gpoly);
        logic [32:0] r;
        r = 33'd1;
        for (int unsigned s = 0; s < e; s++) begin
            r = r << 1;
            if (r[deg]) begin
                r = r ^ gpoly;
            end
        end
        return r[31:0];
    endfunction

endpackage

// File: rtl/cyc_parity_gen.sv
module cyc_parity_gen #(
    parameter int unsigned N        = 15,
    parameter int unsigned K        = 7,
    parameter logic [32:0] GEN_POLY = 33'h1D1
) (
    input  logic [K-1:0]   info,
    output logic [N-K-1:0] parity
);
    localparam int unsigned M = N - K;

    logic [M-1:0] term [K];

    // Each information bit contributes a fixed column x^(M+k) mod g(x).
    for (genvar k = 0; k < K; k++) begin : g_col
        localparam logic [31:0] FULL = cyc_enc_pkg::xpow_mod(M + k, M, GEN_POLY);
        localparam logic [M-1:0] COL = FULL[M-1:0];
        assign term[k] = info[k] ? COL : '0;
    end

    always_comb begin
        parity = '0;
        for (int k = 0; k < K; k++) begin
            parity = parity ^ term[k];
        end
    end

endmodule

// File: rtl/cyc_syndrome_chk.sv
module cyc_syndrome_chk #(
    parameter int unsigned N        = 15,
    parameter int unsigned K        = 7,
    parameter logic [32:0] GEN_POLY = 33'h1D1
) (
    input  logic [N-1:0]   word,
    output logic [N-K-1:0] syndrome,
    output logic           err
);
    localparam int unsigned M = N - K;

    logic [M-1:0] term [N];

    // Full parity-check matrix: info position p weighs x^(M+p), parity
    // position K+m weighs x^m. A codeword sums to zero.
    for (genvar p = 0; p < N; p++) begin : g_col
        localparam int unsigned   EXPO = (p < K) ? (M + p) : (p - K);
        localparam logic [31:0]   FULL = cyc_enc_pkg::xpow_mod(EXPO, M, GEN_POLY);
        localparam logic [M-1:0]  COL  = FULL[M-1:0];
        assign term[p] = word[p] ? COL : '0;
    end

    always_comb begin
        syndrome = '0;
        for (int p = 0; p < N; p++) begin
            syndrome = syndrome ^ term[p];
        end
    end

    assign err = |syndrome;

endmodule

// File: rtl/cyc_fault_mask.sv
module cyc_fault_mask #(
    parameter int unsigned M     = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    output logic [M-1:0]     mask
);
    for (genvar m = 0; m < M; m++) begin : g_bit
        localparam logic [SEL_W-1:0] IDX = SEL_W'(m);
        assign mask[m] = enable && (sel == IDX);
    end

endmodule

// File: rtl/cyc_selfcheck_encoder.sv
module cyc_selfcheck_encoder #(
    parameter int unsigned N              = 15,
    parameter int unsigned K              = 7,
    parameter logic [32:0] GEN_POLY       = 33'h1D1,
    parameter int unsigned MAX_RETRY      = 2,
    parameter int unsigned FAULT_ATTEMPTS = 1,
    parameter int unsigned SEL_W          = $clog2(N - K)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [K-1:0]     info,
    input  logic             fault_en,
    input  logic [SEL_W-1:0] fault_sel,
    output logic [N-1:0]     codeword,
    output logic             done,
    output logic             fail
);
    localparam int unsigned M        = N - K;
    localparam int unsigned AW       = $clog2(MAX_RETRY + 2);
    localparam int unsigned FA_CLAMP = (FAULT_ATTEMPTS > MAX_RETRY + 1) ?
                                       (MAX_RETRY + 1) : FAULT_ATTEMPTS;
    localparam logic [AW-1:0] FA_LIM    = AW'(FA_CLAMP);
    localparam logic [AW-1:0] RETRY_LIM = AW'(MAX_RETRY);

    typedef struct packed {
        cyc_enc_pkg::enc_state_e st;
        logic [K-1:0]            info;
        logic                    fen;
        logic [SEL_W-1:0]        fsel;
        logic [AW-1:0]           att;
        logic [N-1:0]            cand;
        logic [N-1:0]            cw;
        logic                    done;
        logic                    fail;
    } regs_t;

    regs_t r_q, r_d;

    logic [M-1:0] parity;
    logic [M-1:0] fmask;
    logic [M-1:0] syndrome;
    logic         chk_err;
    logic         inject;

    assign inject = r_q.fen && (r_q.att < FA_LIM);

    cyc_parity_gen #(.N(N), .K(K), .GEN_POLY(GEN_POLY)) u_gen (
        .info   (r_q.info),
        .parity (parity)
    );

    cyc_fault_mask #(.M(M), .SEL_W(SEL_W)) u_mask (
        .enable (inject),
        .sel    (r_q.fsel),
        .mask   (fmask)
    );

    cyc_syndrome_chk #(.N(N), .K(K), .GEN_POLY(GEN_POLY)) u_chk (
        .word     (r_q.cand),
        .syndrome (syndrome),
        .err      (chk_err)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            cyc_enc_pkg::ST_IDLE: begin
                if (start) begin
                    r_d.info = info;
                    r_d.fen  = fault_en;
                    r_d.fsel = fault_sel;
                    r_d.att  = '0;
                    r_d.st   = cyc_enc_pkg::ST_ENC;
                end
            end
            cyc_enc_pkg::ST_ENC: begin
                r_d.cand = {parity ^ fmask, r_q.info};
                r_d.st   = cyc_enc_pkg::ST_CHK;
            end
            cyc_enc_pkg::ST_CHK: begin
                if (!chk_err) begin
                    r_d.cw   = r_q.cand;
                    r_d.done = 1'b1;
                    r_d.fail = 1'b0;
                    r_d.st   = cyc_enc_pkg::ST_IDLE;
                end else if (r_q.att == RETRY_LIM) begin
                    r_d.cw   = r_q.cand;
                    r_d.done = 1'b1;
                    r_d.fail = 1'b1;
                    r_d.st   = cyc_enc_pkg::ST_IDLE;
                end else begin
                    r_d.att = r_q.att + AW'(1);
                    r_d.st  = cyc_enc_pkg::ST_ENC;
                end
            end
            default: r_d.st = cyc_enc_pkg::ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: cyc_enc_pkg::ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign codeword = r_q.cw;
    assign done     = r_q.done;
    assign fail     = r_q.fail;

    // R4: completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: released word carries the captured information bits
    p_systematic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (codeword[K-1:0] == r_q.info));

    // R5: a good completion follows a clean check result
    p_clean_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> $past(!chk_err));

    // R6: failure only once the retry budget is exhausted
    p_fail_at_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> ($past(r_q.att) == RETRY_LIM));

    // R6: attempt counter never passes the budget
    p_attempt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.att <= RETRY_LIM);

    // R8: outputs hold between completions
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !r_d.done |=> ($stable(codeword) && $stable(fail)));

    // R7: a new request is only taken from idle
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != cyc_enc_pkg::ST_IDLE) |=> $stable(r_q.info));

endmodule

// File: tb/tb_cyc_selfcheck_encoder.sv
module tb_cyc_selfcheck_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_a = 1'b0;
    logic        start_b = 1'b0;
    logic [6:0]  info = '0;
    logic        fault_en = 1'b0;
    logic [2:0]  fault_sel = '0;
    logic [14:0] cw_a, cw_b;
    logic        done_a, done_b, fail_a, fail_b;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cyc_selfcheck_encoder dut (
        .clk(clk), .rst_n(rst_n), .start(start_a), .info(info),
        .fault_en(fault_en), .fault_sel(fault_sel),
        .codeword(cw_a), .done(done_a), .fail(fail_a)
    );

    cyc_selfcheck_encoder #(.FAULT_ATTEMPTS(3)) dut_stuck (
        .clk(clk), .rst_n(rst_n), .start(start_b), .info(info),
        .fault_en(fault_en), .fault_sel(fault_sel),
        .codeword(cw_b), .done(done_b), .fail(fail_b)
    );

    // Codewords {parity, info}; parity from x^(8+k) mod g(x) columns.
    localparam logic [14:0] VEC [8] = '{
        15'h6881, 15'h7440, 15'h7FFF, 15'h0000,
        15'h1B85, 15'h0D2A, 15'h72D5, 15'h2492
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit use_b, input logic [6:0] inf, input bit fen,
                          input logic [2:0] fs, output int lat,
                          output logic [14:0] cw, output bit fl);
        info = inf; fault_en = fen; fault_sel = fs;
        if (use_b) start_b = 1'b1; else start_a = 1'b1;
        lat = 0;
        for (int c = 1; c <= 20; c++) begin
            @(negedge clk);
            start_a = 1'b0; start_b = 1'b0;
            if (use_b ? done_b : done_a) begin
                lat = c;
                break;
            end
        end
        cw = use_b ? cw_b : cw_a;
        fl = use_b ? fail_b : fail_a;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        finish_run();
    end

    initial begin
        int lat;
        logic [14:0] cw;
        bit fl;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(cw_a == 15'h0 && cw_b == 15'h0, "R1 codeword", {17'h0, cw_a}, 32'h0);
        check(!done_a && !fail_a && !done_b && !fail_b, "R1 flags",
              {28'h0, done_a, fail_a, done_b, fail_b}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2, R3, R4
        for (int i = 0; i < 8; i++) begin
            run_op(1'b0, VEC[i][6:0], 1'b0, 3'd0, lat, cw, fl);
            check(cw[6:0] == VEC[i][6:0], "R2 info bits", {25'h0, cw[6:0]}, {25'h0, VEC[i][6:0]});
            check(cw[14:7] == VEC[i][14:7], "R3 parity", {24'h0, cw[14:7]}, {24'h0, VEC[i][14:7]});
            check(lat == 3, "R4 latency", lat, 3);
            check(!fl, "R4 fail low", {31'h0, fl}, 0);
            @(negedge clk);
            check(!done_a, "R4 single pulse", {31'h0, done_a}, 0);
        end

        // R5: fault on first attempt only, recovered by retry
        run_op(1'b0, 7'h2A, 1'b1, 3'd5, lat, cw, fl);
        check(cw == 15'h0D2A, "R5 recovered word", {17'h0, cw}, 32'h0D2A);
        check(!fl, "R5 fail low", {31'h0, fl}, 0);
        check(lat == 5, "R5 retry latency", lat, 5);
        @(negedge clk);
        run_op(1'b0, 7'h7F, 1'b1, 3'd0, lat, cw, fl);
        check(cw == 15'h7FFF && !fl && lat == 5, "R5 recovered all-ones",
              {17'h0, cw}, 32'h7FFF);

        // R6: persistent fault exhausts the budget
        @(negedge clk);
        run_op(1'b1, 7'h05, 1'b1, 3'd2, lat, cw, fl);
        check(fl, "R6 fail set", {31'h0, fl}, 1);
        check(lat == 7, "R6 latency", lat, 7);
        check(cw == 15'h1985, "R6 flipped parity", {17'h0, cw}, 32'h1985);
        // R8: fail and codeword hold
        repeat (4) @(negedge clk);
        check(fail_b && cw_b == 15'h1985 && !done_b, "R8 hold after fail",
              {16'h0, fail_b, cw_b}, {16'h0, 1'b1, 15'h1985});
        // same instance without fault: clean
        run_op(1'b1, 7'h55, 1'b0, 3'd0, lat, cw, fl);
        check(cw == 15'h72D5 && !fl && lat == 3, "R6 clean on stuck instance",
              {17'h0, cw}, 32'h72D5);

        // R7: start during busy ignored
        @(negedge clk);
        info = 7'h01; fault_en = 1'b0; start_a = 1'b1;
        @(negedge clk);
        info = 7'h40; start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        check(!done_a, "R7 no early done", {31'h0, done_a}, 0);
        @(negedge clk);
        check(done_a && cw_a == 15'h6881, "R7 first result kept",
              {17'h0, cw_a}, 32'h6881);
        begin
            int extra = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (done_a) extra++;
            end
            check(extra == 0, "R7 no extra done", extra, 0);
        end
        // R8: codeword held with no completion
        check(cw_a == 15'h6881 && !fail_a, "R8 hold", {17'h0, cw_a}, 32'h6881);

        finish_run();
    end

endmodule